// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit watches the synchronized input pins of a GPIO port and turns configured pin events into pending flags and a single combined interrupt line. Every pin is set up on its own as level-sensitive (high or low) or edge-sensitive (rising, falling, or both). Software enables pins through a write-one-to-set register, disables them through a write-one-to-clear register, and reads the resulting enable mask back from its own offset.

Pending flags collect in a status register. One read returns every flag and clears all of them in the same access. A flag is recorded whether or not its pin is enabled. The interrupt output is a registered OR of the flags whose pins are enabled. Pin direction and output drive are handled elsewhere in the port.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the mask, status, type, value and any-edge registers are all zero, `irq_o` is 0 and `reg_rdata` is 0.
- R2: A write to offset 0x18 sets every mask bit whose write-data bit is 1. A write to offset 0x1C clears every mask bit whose write-data bit is 1. Mask bits written as 0 keep their value. The mask reads back at offset 0x14, with bit i = 1 meaning pin i is enabled.
- R3: The type (0x24), value (0x28) and any-edge (0x2C) registers are written whole and read back unchanged. Writes to 0x14 and 0x20 change nothing. Reads of any unmapped offset return 0.
- R4: Type bit 1 selects level detection. Value bit 1 flags a high pin and value bit 0 flags a low pin.
- R5: Type bit 0 selects edge detection. Value bit 1 flags a rising transition and value bit 0 flags a falling transition.
- R6: When the any-edge bit is 1 on an edge-type pin, both transitions are flagged and the value bit is ignored. The any-edge bit has no effect on a level-type pin.
- R7: A read strobe returns its data on `reg_rdata` in the next cycle, and `reg_rdata` is 0 in cycles that follow no read. A read at 0x20 returns the flags held before the access and clears all of them.
- R8: An event that arrives in the same cycle as a clearing status read leaves its flag set.
- R9: Status flags latch for masked pins too. `irq_o` equals the OR of (status AND mask) as it stood one cycle earlier.
- R10: A level-type flag is set again on every cycle while its condition holds, so it comes back after a clearing read.
- R11: Edges are found by comparing the pin with its value sampled on the previous clock. The previous sample is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset of the access |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with its defaults: 32 pins, a 32-bit data path and an 8-bit offset. This puts every pin position, including the top bit, under random configuration, so level, rising, falling and both-edge pins all run side by side while pins toggle sparsely. Directed passages set up a clearing read that coincides with a fresh edge, a level flag that comes back after it is cleared, and masked pins that latch flags without raising the interrupt. A cycle-accurate model in the bench predicts `irq_o` and `reg_rdata` for every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // byte offsets of the register window
   localparam int unsigned OFS_MASK = 32'h14;
   localparam int unsigned OFS_EN   = 32'h18;
   localparam int unsigned OFS_DIS  = 32'h1C;
   localparam int unsigned OFS_STAT = 32'h20;
   localparam int unsigned OFS_TYPE = 32'h24;
   localparam int unsigned OFS_VAL  = 32'h28;
   localparam int unsigned OFS_ANY  = 32'h2C;

   localparam int unsigned MIN_AW = 6;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_MASK,
      RSEL_STAT,
      RSEL_TYPE,
      RSEL_VAL,
      RSEL_ANY
   } rsel_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [NPIN-1:0] mask_o,
   output logic [NPIN-1:0] typ_o,
   output logic [NPIN-1:0] val_o,
   output logic [NPIN-1:0] any_o
);

   localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
   localparam logic [AW-1:0] A_DIS  = AW'(OFS_DIS);
   localparam logic [AW-1:0] A_TYPE = AW'(OFS_TYPE);
   localparam logic [AW-1:0] A_VAL  = AW'(OFS_VAL);
   localparam logic [AW-1:0] A_ANY  = AW'(OFS_ANY);

   logic [NPIN-1:0] wbits;
   logic            we_en, we_dis, we_typ, we_val, we_any;
   logic [NPIN-1:0] mask_q, typ_q, val_q, any_q;
   logic [NPIN-1:0] mask_d;

   assign wbits  = reg_wdata[NPIN-1:0];
   assign we_en  = reg_wr && (reg_addr == A_EN);
   assign we_dis = reg_wr && (reg_addr == A_DIS);
   assign we_typ = reg_wr && (reg_addr == A_TYPE);
   assign we_val = reg_wr && (reg_addr == A_VAL);
   assign we_any = reg_wr && (reg_addr == A_ANY);

   // set and clear are decoded from different offsets, never both at once
   always_comb begin
      mask_d = mask_q;
      if (we_en)  mask_d = mask_q | wbits;
      if (we_dis) mask_d = mask_q & ~wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         typ_q  <= '0;
         val_q  <= '0;
         any_q  <= '0;
      end else begin
         mask_q <= mask_d;
         if (we_typ) typ_q <= wbits;
         if (we_val) val_q <= wbits;
         if (we_any) any_q <= wbits;
      end
   end

   assign mask_o = mask_q;
   assign typ_o  = typ_q;
   assign val_o  = val_q;
   assign any_o  = any_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_i,
   input  logic [NPIN-1:0] typ_i,
   input  logic [NPIN-1:0] val_i,
   input  logic [NPIN-1:0] any_i,
   output logic [NPIN-1:0] evt_o
);

   logic [NPIN-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_i;
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic rise, fall, lvl_hit, dir_hit, edg_hit;
      assign rise    = pin_i[i] & ~prev_q[i];
      assign fall    = ~pin_i[i] & prev_q[i];
      assign lvl_hit = val_i[i] ? pin_i[i] : ~pin_i[i];
      assign dir_hit = val_i[i] ? rise : fall;
      assign edg_hit = any_i[i] ? (rise | fall) : dir_hit;
      assign evt_o[i] = typ_i[i] ? lvl_hit : edg_hit;
   end

endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
   parameter int unsigned NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] evt_i,
   input  logic            clr_i,
   input  logic [NPIN-1:0] mask_i,
   output logic [NPIN-1:0] status_o,
   output logic            irq_o
);

   logic [NPIN-1:0] status_q, status_d;
   logic            irq_q;

   // a fresh event beats the clearing read
   assign status_d = (clr_i ? '0 : status_q) | evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         irq_q    <= |(status_q & mask_i);
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

endmodule

// File: rtl/gpio_irq_rdport.sv
module gpio_irq_rdport
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_rd,
   input  logic [AW-1:0]   reg_addr,
   input  logic [NPIN-1:0] mask_i,
   input  logic [NPIN-1:0] status_i,
   input  logic [NPIN-1:0] typ_i,
   input  logic [NPIN-1:0] val_i,
   input  logic [NPIN-1:0] any_i,
   output logic            clr_o,
   output logic [DW-1:0]   rdata_o
);

   rsel_e           sel;
   logic [NPIN-1:0] mux;
   logic [DW-1:0]   rdata_q;

   always_comb begin
      unique case (reg_addr)
         AW'(OFS_MASK): sel = RSEL_MASK;
         AW'(OFS_STAT): sel = RSEL_STAT;
         AW'(OFS_TYPE): sel = RSEL_TYPE;
         AW'(OFS_VAL):  sel = RSEL_VAL;
         AW'(OFS_ANY):  sel = RSEL_ANY;
         default:       sel = RSEL_NONE;
      endcase
   end

   always_comb begin
      case (sel)
         RSEL_MASK: mux = mask_i;
         RSEL_STAT: mux = status_i;
         RSEL_TYPE: mux = typ_i;
         RSEL_VAL:  mux = val_i;
         RSEL_ANY:  mux = any_i;
         default:   mux = '0;
      endcase
   end

   assign clr_o = reg_rd && (sel == RSEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= DW'(mux);
      else             rdata_q <= '0;
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_i,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            irq_o
);

   if (NPIN < 1 || NPIN > DW) begin : g_bad_npin
      $error("gpio_irq_unit: NPIN must be in 1..DW");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("gpio_irq_unit: AW too small for the register window");
   end

   logic [NPIN-1:0] mask_q, typ_q, val_q, any_q;
   logic [NPIN-1:0] evt_vec, status_q;
   logic            stat_clr;

   gpio_irq_cfg #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mask_o(mask_q), .typ_o(typ_q),
      .val_o(val_q), .any_o(any_q)
   );

   gpio_irq_detect #(.NPIN(NPIN)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .typ_i(typ_q),
      .val_i(val_q), .any_i(any_q), .evt_o(evt_vec)
   );

   gpio_irq_flags #(.NPIN(NPIN)) u_flg (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .clr_i(stat_clr),
      .mask_i(mask_q), .status_o(status_q), .irq_o(irq_o)
   );

   gpio_irq_rdport #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_rd (
      .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .mask_i(mask_q), .status_i(status_q), .typ_i(typ_q), .val_i(val_q),
      .any_i(any_q), .clr_o(stat_clr), .rdata_o(reg_rdata)
   );

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr,
   input logic            reg_rd,
   input logic [AW-1:0]   reg_addr,
   input logic [DW-1:0]   reg_wdata,
   input logic [DW-1:0]   reg_rdata,
   input logic            irq_o,
   input logic [NPIN-1:0] mask,
   input logic [NPIN-1:0] status,
   input logic [NPIN-1:0] evt
);

   a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(OFS_EN)) |=>
         ((mask & $past(reg_wdata[NPIN-1:0])) == $past(reg_wdata[NPIN-1:0])));

   a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(OFS_DIS)) |=>
         ((mask & $past(reg_wdata[NPIN-1:0])) == '0));

   a_r7_read_returns_old: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == AW'(OFS_STAT)) |=> (reg_rdata == DW'($past(status))));

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == AW'(OFS_STAT) && evt == '0) |=> (status == '0));

   a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

   a_r9_quiet_when_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & mask) == '0) |=> !irq_o);

   a_r9_raised_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & mask) != '0) |=> irq_o);

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .irq_o(irq_o), .mask(mask_q), .status(status_q), .evt(evt_vec)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;

   localparam int NP = 32;
   localparam logic [7:0] A_MASK = 8'h14, A_EN = 8'h18, A_DIS = 8'h1C,
                          A_STAT = 8'h20, A_TYPE = 8'h24, A_VAL = 8'h28,
                          A_ANY = 8'h2C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_i = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   // reference model state
   logic [NP-1:0] m_mask = '0, m_stat = '0, m_typ = '0, m_val = '0, m_any = '0, m_prev = '0;
   logic          m_irq = 1'b0;
   logic [31:0]   m_rdata = '0;
   logic [NP-1:0] cur_pins = '0;

   always #2 clk = ~clk;

   gpio_irq_unit u_gpio_irq_unit (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   function automatic logic [NP-1:0] events(logic [NP-1:0] p, logic [NP-1:0] pv,
                                            logic [NP-1:0] t, logic [NP-1:0] v,
                                            logic [NP-1:0] a);
      logic [NP-1:0] r;
      for (int i = 0; i < NP; i++) begin
         logic rise, fall;
         rise = p[i] & ~pv[i];
         fall = ~p[i] & pv[i];
         if (t[i])      r[i] = v[i] ? p[i] : ~p[i];
         else if (a[i]) r[i] = rise | fall;
         else           r[i] = v[i] ? rise : fall;
      end
      return r;
   endfunction

   function automatic logic [31:0] peek(logic [7:0] a);
      case (a)
         A_MASK: return m_mask;
         A_STAT: return m_stat;
         A_TYPE: return m_typ;
         A_VAL:  return m_val;
         A_ANY:  return m_any;
         default: return '0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, advance model, compare after posedge
   task automatic step(input logic [NP-1:0] pins, input bit wr, input bit rd,
                       input logic [7:0] addr, input logic [31:0] wd, input string tag);
      logic [NP-1:0] evt, n_stat, n_mask;
      logic          n_irq;
      logic [31:0]   n_rdata;
      @(negedge clk);
      pin_i = pins; reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
      evt     = events(pins, m_prev, m_typ, m_val, m_any);
      n_stat  = ((rd && addr == A_STAT) ? '0 : m_stat) | evt;
      n_irq   = |(m_stat & m_mask);
      n_rdata = rd ? peek(addr) : 32'h0;
      n_mask  = m_mask;
      if (wr && addr == A_EN)  n_mask = m_mask | wd;
      if (wr && addr == A_DIS) n_mask = m_mask & ~wd;
      @(posedge clk);
      #1;
      if (wr && addr == A_TYPE) m_typ = wd;
      if (wr && addr == A_VAL)  m_val = wd;
      if (wr && addr == A_ANY)  m_any = wd;
      m_mask = n_mask; m_stat = n_stat; m_irq = n_irq; m_rdata = n_rdata; m_prev = pins;
      cur_pins = pins;
      check(irq_o === m_irq, tag, "irq_o", {31'h0, irq_o}, {31'h0, m_irq});
      check(reg_rdata === m_rdata, tag, "reg_rdata", reg_rdata, m_rdata);
      reg_wr = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(cur_pins, 1'b1, 1'b0, a, d, tag);
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      step(cur_pins, 1'b0, 1'b1, a, 32'h0, tag);
   endtask

   task automatic idle(input logic [NP-1:0] p, input string tag);
      step(p, 1'b0, 1'b0, 8'h00, 32'h0, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values at the ports
      check(irq_o === 1'b0, "R1", "irq_o after reset", {31'h0, irq_o}, 32'h0);
      check(reg_rdata === 32'h0, "R1", "rdata after reset", reg_rdata, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      rd(A_MASK, "R1"); rd(A_STAT, "R1"); rd(A_TYPE, "R1"); rd(A_VAL, "R1"); rd(A_ANY, "R1");
      idle('0, "R1");

      // R2: write-one set and clear of the mask
      wr(A_EN, 32'h0000_00F0, "R2"); wr(A_DIS, 32'h0000_0030, "R2");
      wr(A_EN, 32'h0, "R2"); wr(A_DIS, 32'h0, "R2"); rd(A_MASK, "R2");
      wr(A_DIS, 32'hFFFF_FFFF, "R2"); rd(A_MASK, "R2");

      // R3: config readback, read-only offsets, unmapped offset
      wr(A_TYPE, 32'hA5A5_0F0F, "R3"); wr(A_VAL, 32'h1234_5678, "R3");
      wr(A_ANY, 32'h8000_0001, "R3");
      rd(A_TYPE, "R3"); rd(A_VAL, "R3"); rd(A_ANY, "R3");
      wr(A_MASK, 32'hFFFF_FFFF, "R3"); wr(A_STAT, 32'hFFFF_FFFF, "R3");
      rd(A_MASK, "R3"); rd(8'h30, "R3"); rd(8'h00, "R3");
      wr(A_TYPE, 32'h0, "R3"); wr(A_VAL, 32'h0, "R3"); wr(A_ANY, 32'h0, "R3");
      rd(A_STAT, "R3"); idle('0, "R3");

      // R4/R10: level high on pin 0, level low on pin 4, any-edge ignored on pin 0
      wr(A_TYPE, 32'h11, "R4"); wr(A_VAL, 32'h01, "R4"); wr(A_ANY, 32'h01, "R6");
      wr(A_EN, 32'h01, "R4");
      idle(32'h0000_0010, "R4"); idle(32'h0000_0011, "R4"); idle(32'h0000_0011, "R4");
      rd(A_STAT, "R10"); rd(A_STAT, "R10"); idle(32'h0000_0010, "R4");
      rd(A_STAT, "R10"); idle('0, "R4"); rd(A_STAT, "R4"); rd(A_STAT, "R4");

      // R5/R11: rising on pin 1, falling on pin 2
      wr(A_TYPE, 32'h0, "R5"); wr(A_ANY, 32'h0, "R5"); wr(A_VAL, 32'h02, "R5");
      wr(A_EN, 32'h06, "R5"); rd(A_STAT, "R5");
      idle(32'h6, "R11"); idle(32'h6, "R11"); rd(A_STAT, "R5");
      idle(32'h0, "R11"); idle(32'h0, "R11"); rd(A_STAT, "R5");

      // R6: both edges on pin 3 regardless of value bit
      wr(A_ANY, 32'h08, "R6"); wr(A_EN, 32'h08, "R6");
      idle(32'h8, "R6"); rd(A_STAT, "R6"); idle(32'h0, "R6"); rd(A_STAT, "R6");

      // R8: new edge in the same cycle as the clearing read
      idle(32'h0, "R8");
      step(32'h2, 1'b0, 1'b1, A_STAT, 32'h0, "R8");
      idle(32'h2, "R8"); rd(A_STAT, "R8");

      // R9: masked pins latch flags but raise no interrupt
      wr(A_DIS, 32'hFFFF_FFFF, "R9"); idle(32'h0, "R9"); idle(32'h2, "R9");
      idle(32'h2, "R9"); rd(A_STAT, "R9"); idle(32'h0, "R9"); idle(32'h2, "R9");
      wr(A_EN, 32'h2, "R9"); idle(32'h2, "R9"); rd(A_STAT, "R9");

      // constrained random traffic
      for (int k = 0; k < 3000; k++) begin
         logic [NP-1:0] p;
         int op;
         logic [7:0] ra;
         p  = cur_pins ^ ($urandom & $urandom & $urandom);
         op = $urandom % 10;
         case (op % 8)
            0: step(p, 1'b1, 1'b0, A_EN,   $urandom, "R2");
            1: step(p, 1'b1, 1'b0, A_DIS,  $urandom & $urandom, "R2");
            2: step(p, 1'b1, 1'b0, A_TYPE, $urandom & $urandom, "R4");
            3: step(p, 1'b1, 1'b0, A_VAL,  $urandom, "R5");
            4: step(p, 1'b1, 1'b0, A_ANY,  $urandom, "R6");
            5: step(p, 1'b0, 1'b1, A_STAT, 32'h0, "R7");
            6: begin
               ra = 8'h14 + 8'(4 * ($urandom % 7));
               step(p, 1'b0, 1'b1, ra, 32'h0, "R7");
            end
            default: step(p, 1'b0, 1'b0, 8'h00, 32'h0, "R9");
         endcase
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule